// File: doc/BRIEF.md
# Gated DAC Output Register Bank

This block holds the setpoint words for a bank of analog output channels and decides what value each channel drives. Software writes setpoints and one control word over a simple single-cycle register bus. Two writable bits in the control word, a load bit and an enable bit, set the mode. In pass mode a setpoint write reaches its output at once. In hold mode setpoint writes are stored, but the outputs keep their last value. In off mode every output is forced to zero.

Each channel has a one-cycle strobe. It pulses whenever that channel's driven value is refreshed, so that a converter interface further down the chip knows when to send a new word. Reads return the stored setpoint, not the driven value. This lets software stage a full new set of values while the outputs are held or forced off, and then release them together with one control write.

Top module: `dac_gate_bank`

## Requirements
- R1: After reset, every setpoint reads 0x3FFF, every output drives 0x3FFF, every strobe is low, and the control word reads 0x060006C0 (enable bit 26 set, load bit 23 clear).
- R2: The control word sits at byte offset 0x00. A write changes only bit 23 (load) and bit 26 (enable). All other bits keep their fixed value from 0x060006C0.
- R3: Setpoint channel i sits at byte offset 0x20 + 2*i and stores bits 15:0 of the write data. Read data appears on the cycle after the read request. Reads of any other address return 0, and writes to any other address change nothing.
- R4: In pass mode (load 0, enable 1), a write to setpoint i drives that value on output i on the next cycle and pulses strobe i. No other channel changes.
- R5: In hold mode (load 1, enable 1), setpoint writes are stored, but the outputs and strobes do not change.
- R6: A control write that leaves load 0 and enable 1 makes every output take its current setpoint on the next cycle, with every strobe pulsing.
- R7: A control write that clears enable forces every output to zero on the next cycle, with every strobe pulsing. While enable stays 0, setpoint writes leave the outputs at zero and raise no strobe.
- R8: Reading a setpoint returns the stored value, even when the driven value differs because of hold or off mode.
- R9: A strobe lasts exactly one cycle after a single update. It is low on the following idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write request for this cycle |
| bus_rd | input | 1 | Read request for this cycle |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| dac_out | output | 128 | Driven words; channel i in bits 16*i+15:16*i |
| dac_stb | output | 8 | Per-channel refresh strobes |

## Verification
The bench sweeps every load/enable combination and writes every channel in each mode. A design that decoded the mode from the new control word instead of the current one, or that let hold mode leak writes through, would show outputs moving without cause. It also writes all-ones and all-zeros control words. A design that let fixed bits become writable, or that failed to reload or zero all channels together on a mode change, would read back a different control word or miss a strobe. Odd and out-of-range addresses are hit to catch loose decoding that would alias onto a neighbouring channel. Reads during hold and off mode catch a design that returns the driven value instead of the stored setpoint.

// File: rtl/dac_gate_pkg.sv
package dac_gate_pkg;

   // Mode derived from the two writable control bits
   typedef enum logic [1:0] {
      DAC_MODE_OFF  = 2'd0,
      DAC_MODE_PASS = 2'd1,
      DAC_MODE_HOLD = 2'd2
   } dac_mode_e;

   // Per-cycle update events fanned out to every channel
   typedef struct packed {
      logic zero_all;
      logic reload_all;
      logic pass;
   } dac_evt_t;

   function automatic dac_mode_e dac_mode(input logic load, input logic en);
      if (!en) return DAC_MODE_OFF;
      if (load) return DAC_MODE_HOLD;
      return DAC_MODE_PASS;
   endfunction

endpackage

// File: rtl/dac_gate_decode.sv
module dac_gate_decode #(
   parameter int ADDR_W    = 7,
   parameter int NUM_CH    = 8,
   parameter int SP_BASE   = 32,
   parameter int SP_STRIDE = 2,
   parameter int CTRL_ADDR = 0,
   localparam int IDX_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              ctrl_hit,
   output logic [NUM_CH-1:0] sp_hit,
   output logic              sp_any,
   output logic [IDX_W-1:0]  sp_idx
);

   assign ctrl_hit = (addr == ADDR_W'(CTRL_ADDR));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
      assign sp_hit[c] = (addr == ADDR_W'(SP_BASE + c * SP_STRIDE));
   end

   assign sp_any = |sp_hit;

   always_comb begin
      sp_idx = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (sp_hit[i]) sp_idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/dac_gate_ctrl.sv
module dac_gate_ctrl
   import dac_gate_pkg::*;
#(
   parameter int               CTRL_W     = 32,
   parameter int               LOAD_BIT   = 23,
   parameter int               ENABLE_BIT = 26,
   parameter logic [CTRL_W-1:0] CTRL_FIXED = 32'h0600_06C0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [CTRL_W-1:0] wdata,
   output logic [CTRL_W-1:0] ctrl_q,
   output dac_evt_t          evt
);

   localparam logic [CTRL_W-1:0] WMASK =
      (CTRL_W'(1) << LOAD_BIT) | (CTRL_W'(1) << ENABLE_BIT);

   logic [CTRL_W-1:0] ctrl_next;
   dac_mode_e         mode_now;
   dac_mode_e         mode_new;

   assign ctrl_next = (CTRL_FIXED & ~WMASK) | (wdata & WMASK);
   assign mode_now  = dac_mode(ctrl_q[LOAD_BIT], ctrl_q[ENABLE_BIT]);
   assign mode_new  = dac_mode(wdata[LOAD_BIT], wdata[ENABLE_BIT]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ctrl_q <= CTRL_FIXED;
      else if (wr) ctrl_q <= ctrl_next;
   end

   assign evt.zero_all   = wr && (mode_new == DAC_MODE_OFF);
   assign evt.reload_all = wr && (mode_new == DAC_MODE_PASS);
   assign evt.pass       = (mode_now == DAC_MODE_PASS);

endmodule

// File: rtl/dac_gate_channel.sv
module dac_gate_channel
   import dac_gate_pkg::*;
#(
   parameter int                DATA_W   = 16,
   parameter logic [DATA_W-1:0] SP_RESET = 16'h3FFF,
   parameter logic [DATA_W-1:0] OUT_RST  = 16'h3FFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sp_we,
   input  logic [DATA_W-1:0] wdata,
   input  dac_evt_t          evt,
   output logic [DATA_W-1:0] sp_q,
   output logic [DATA_W-1:0] out_q,
   output logic              stb_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sp_q  <= SP_RESET;
         out_q <= OUT_RST;
         stb_q <= 1'b0;
      end else begin
         stb_q <= 1'b0;
         if (sp_we) sp_q <= wdata;
         if (evt.zero_all) begin
            out_q <= '0;
            stb_q <= 1'b1;
         end else if (evt.reload_all) begin
            out_q <= sp_q;
            stb_q <= 1'b1;
         end else if (sp_we && evt.pass) begin
            out_q <= wdata;
            stb_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/dac_gate_bank.sv
module dac_gate_bank
   import dac_gate_pkg::*;
#(
   parameter int                NUM_CH     = 8,
   parameter int                DATA_W     = 16,
   parameter int                CTRL_W     = 32,
   parameter int                ADDR_W     = 7,
   parameter int                SP_BASE    = 32,
   parameter int                CTRL_ADDR  = 0,
   parameter int                LOAD_BIT   = 23,
   parameter int                ENABLE_BIT = 26,
   parameter logic [CTRL_W-1:0] CTRL_FIXED = 32'h0600_06C0,
   parameter logic [DATA_W-1:0] SP_RESET   = 16'h3FFF,
   parameter bit                READ_REG   = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_wr,
   input  logic                     bus_rd,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [CTRL_W-1:0]        bus_wdata,
   output logic [CTRL_W-1:0]        bus_rdata,
   output logic [NUM_CH*DATA_W-1:0] dac_out,
   output logic [NUM_CH-1:0]        dac_stb
);

   localparam int SP_STRIDE = DATA_W / 8;
   localparam int IDX_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam logic [DATA_W-1:0] OUT_RST = CTRL_FIXED[ENABLE_BIT] ? SP_RESET : '0;

   // Elaboration-time parameter checks
   if (NUM_CH < 1) begin : g_err_ch
      $error("NUM_CH must be at least 1");
   end
   if (DATA_W % 8 != 0 || DATA_W > CTRL_W) begin : g_err_w
      $error("DATA_W must be whole bytes and fit in CTRL_W");
   end
   if (LOAD_BIT == ENABLE_BIT || LOAD_BIT >= CTRL_W || ENABLE_BIT >= CTRL_W) begin : g_err_bits
      $error("LOAD_BIT and ENABLE_BIT must differ and lie inside CTRL_W");
   end
   if (SP_BASE + NUM_CH * SP_STRIDE > (1 << ADDR_W)) begin : g_err_map
      $error("setpoint window exceeds the address space");
   end
   if (CTRL_ADDR >= SP_BASE && CTRL_ADDR < SP_BASE + NUM_CH * SP_STRIDE) begin : g_err_ovl
      $error("control word overlaps the setpoint window");
   end

   logic              ctrl_hit;
   logic [NUM_CH-1:0] sp_hit;
   logic              sp_any;
   logic [IDX_W-1:0]  sp_idx;
   logic              ctrl_wr;
   logic [CTRL_W-1:0] ctrl_q;
   dac_evt_t          evt;
   logic [DATA_W-1:0] sp_arr [NUM_CH];
   logic [CTRL_W-1:0] rd_val;

   dac_gate_decode #(
      .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .SP_BASE(SP_BASE),
      .SP_STRIDE(SP_STRIDE), .CTRL_ADDR(CTRL_ADDR)
   ) i_decode (
      .addr(bus_addr), .ctrl_hit(ctrl_hit), .sp_hit(sp_hit),
      .sp_any(sp_any), .sp_idx(sp_idx)
   );

   assign ctrl_wr = bus_wr && ctrl_hit;

   dac_gate_ctrl #(
      .CTRL_W(CTRL_W), .LOAD_BIT(LOAD_BIT), .ENABLE_BIT(ENABLE_BIT),
      .CTRL_FIXED(CTRL_FIXED)
   ) i_ctrl (
      .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(bus_wdata),
      .ctrl_q(ctrl_q), .evt(evt)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dac_gate_channel #(
         .DATA_W(DATA_W), .SP_RESET(SP_RESET), .OUT_RST(OUT_RST)
      ) i_channel (
         .clk(clk), .rst_n(rst_n),
         .sp_we(bus_wr && sp_hit[c]),
         .wdata(bus_wdata[DATA_W-1:0]),
         .evt(evt),
         .sp_q(sp_arr[c]),
         .out_q(dac_out[c*DATA_W +: DATA_W]),
         .stb_q(dac_stb[c])
      );
   end

   always_comb begin
      rd_val = '0;
      if (ctrl_hit)    rd_val = ctrl_q;
      else if (sp_any) rd_val = CTRL_W'(sp_arr[sp_idx]);
   end

   if (READ_REG) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      bus_rdata <= '0;
         else if (bus_rd) bus_rdata <= rd_val;
      end
   end else begin : g_rd_comb
      assign bus_rdata = bus_rd ? rd_val : '0;
   end

endmodule

// File: rtl/dac_gate_bank_chk.sv
module dac_gate_bank_chk #(
   parameter int                NUM_CH     = 8,
   parameter int                DATA_W     = 16,
   parameter int                CTRL_W     = 32,
   parameter int                LOAD_BIT   = 23,
   parameter int                ENABLE_BIT = 26,
   parameter logic [CTRL_W-1:0] CTRL_FIXED = 32'h0600_06C0
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     ctrl_wr,
   input logic [CTRL_W-1:0]        wdata,
   input logic [CTRL_W-1:0]        ctrl_q,
   input logic [NUM_CH*DATA_W-1:0] dac_out,
   input logic [NUM_CH-1:0]        dac_stb
);

   localparam logic [CTRL_W-1:0] WMASK =
      (CTRL_W'(1) << LOAD_BIT) | (CTRL_W'(1) << ENABLE_BIT);

   // R2
   fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q & ~WMASK) == (CTRL_FIXED & ~WMASK));

   // R5
   hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[ENABLE_BIT] && ctrl_q[LOAD_BIT] && !ctrl_wr)
      |=> ($stable(dac_out) && dac_stb == '0));

   // R6
   reload_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && wdata[ENABLE_BIT] && !wdata[LOAD_BIT]) |=> (&dac_stb));

   // R7
   off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[ENABLE_BIT] |-> (dac_out == '0));

   // R7
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[ENABLE_BIT] && !ctrl_wr) |=> (dac_stb == '0));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      // R4
      change_needs_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(dac_out[c*DATA_W +: DATA_W]) |-> dac_stb[c]);
   end

endmodule

bind dac_gate_bank dac_gate_bank_chk #(
   .NUM_CH(NUM_CH), .DATA_W(DATA_W), .CTRL_W(CTRL_W),
   .LOAD_BIT(LOAD_BIT), .ENABLE_BIT(ENABLE_BIT), .CTRL_FIXED(CTRL_FIXED)
) i_chk (
   .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wdata(bus_wdata),
   .ctrl_q(ctrl_q), .dac_out(dac_out), .dac_stb(dac_stb)
);

// File: tb/test_dac_gate_bank.sv
`timescale 1ns/1ps
module test_dac_gate_bank;

   localparam int          NCH    = 8;
   localparam logic [31:0] FIXED  = 32'h0600_06C0;
   localparam logic [31:0] WMASK  = 32'h0480_0000;
   localparam logic [6:0]  CTRL_A = 7'h00;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [6:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NCH*16-1:0] dac_out;
   logic [NCH-1:0]    dac_stb;

   int checks = 0;
   int errors = 0;

   logic [15:0] exp_sp  [NCH];
   logic [15:0] exp_out [NCH];
   logic [31:0] exp_ctrl;

   always #2 clk = ~clk;

   dac_gate_bank i_dac_gate_bank (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .dac_out(dac_out), .dac_stb(dac_stb)
   );

   task automatic check_outputs(input logic [NCH-1:0] es, input string tag);
      for (int ch = 0; ch < NCH; ch++) begin
         checks++;
         if (dac_out[ch*16 +: 16] !== exp_out[ch]) begin
            errors++;
            $display("FAIL %s ch%0d output actual %h expected %h",
                     tag, ch, dac_out[ch*16 +: 16], exp_out[ch]);
         end
      end
      checks++;
      if (dac_stb !== es) begin
         errors++;
         $display("FAIL %s strobes actual %b expected %b", tag, dac_stb, es);
      end
   endtask

   task automatic bus_write(input logic [6:0] a, input logic [31:0] d, input string tag);
      logic [NCH-1:0] es;
      es = '0;
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      if (a == CTRL_A) begin
         exp_ctrl = (FIXED & ~WMASK) | (d & WMASK);
         if (!exp_ctrl[26]) begin
            for (int ch = 0; ch < NCH; ch++) exp_out[ch] = '0;
            es = '1;
         end else if (!exp_ctrl[23]) begin
            for (int ch = 0; ch < NCH; ch++) exp_out[ch] = exp_sp[ch];
            es = '1;
         end
      end else if (a >= 7'h20 && a <= 7'h2E && !a[0]) begin
         int ch;
         ch = (int'(a) - 32) / 2;
         exp_sp[ch] = d[15:0];
         if (exp_ctrl[26] && !exp_ctrl[23]) begin
            exp_out[ch] = d[15:0];
            es[ch] = 1'b1;
         end
      end
      @(negedge clk);
      bus_wr = 1'b0;
      check_outputs(es, tag);
      @(negedge clk);
      check_outputs('0, "R9 idle after update");
   endtask

   task automatic bus_read(input logic [6:0] a, input logic [31:0] e, input string tag);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      checks++;
      if (bus_rdata !== e) begin
         errors++;
         $display("FAIL %s read addr %h actual %h expected %h", tag, a, bus_rdata, e);
      end
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int ch = 0; ch < NCH; ch++) begin
         exp_sp[ch] = 16'h3FFF;
         exp_out[ch] = 16'h3FFF;
      end
      exp_ctrl = FIXED;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check_outputs('0, "R1 reset");
      bus_read(CTRL_A, FIXED, "R1 control reset");
      for (int ch = 0; ch < NCH; ch++)
         bus_read(7'(32 + 2 * ch), 32'h3FFF, "R1 setpoint reset");

      // R2 only load and enable bits are writable
      bus_write(CTRL_A, 32'hFFFF_FFFF, "R2 all ones");
      bus_read(CTRL_A, 32'h0680_06C0, "R2 readback ones");
      bus_write(CTRL_A, 32'h0000_0000, "R2 all zeros R7");
      bus_read(CTRL_A, 32'h0200_06C0, "R2 readback zeros");

      // Sweep every mode over every channel: R4 R5 R7 R8
      for (int m = 0; m < 4; m++) begin
         logic [31:0] cw;
         cw = (m[0] ? 32'h0080_0000 : 32'h0) | (m[1] ? 32'h0400_0000 : 32'h0);
         bus_write(CTRL_A, cw, "R6 R7 mode entry");
         bus_read(CTRL_A, (FIXED & ~WMASK) | cw, "R2 mode readback");
         for (int ch = 0; ch < NCH; ch++) begin
            logic [15:0] v;
            v = 16'(m * 16'h1357) ^ 16'(ch * 16'h0F0F) ^ 16'hA5A5;
            bus_write(7'(32 + 2 * ch), {16'hBEEF, v}, "R4 R5 R7 setpoint write");
            bus_read(7'(32 + 2 * ch), {16'h0, v}, "R3 R8 setpoint readback");
         end
         check_outputs('0, "R5 R7 after sweep");
      end

      // R6 release from hold and from off reloads all channels
      bus_write(CTRL_A, 32'h0480_0000, "R5 enter hold");
      for (int ch = 0; ch < NCH; ch++)
         bus_write(7'(32 + 2 * ch), 32'(16'h4000 + ch * 3), "R5 staged");
      bus_write(CTRL_A, 32'h0400_0000, "R6 release hold");
      bus_write(CTRL_A, 32'h0000_0000, "R7 force off");
      bus_write(7'h26, 32'h0000_1234, "R7 write while off");
      bus_read(7'h26, 32'h0000_1234, "R8 read while off");
      bus_write(CTRL_A, 32'h0400_0000, "R6 release off");

      // R3 unmapped addresses
      bus_write(7'h21, 32'h0000_DEAD, "R3 odd address");
      bus_write(7'h2F, 32'h0000_DEAD, "R3 odd top");
      bus_write(7'h30, 32'h0000_DEAD, "R3 past window");
      bus_write(7'h1E, 32'h0000_DEAD, "R3 below window");
      bus_write(7'h02, 32'h0000_DEAD, "R3 near control");
      bus_read(7'h21, 32'h0, "R3 unmapped read");
      bus_read(7'h30, 32'h0, "R3 unmapped read");
      bus_read(7'h7F, 32'h0, "R3 unmapped read");
      for (int ch = 0; ch < NCH; ch++)
         bus_read(7'(32 + 2 * ch), {16'h0, exp_sp[ch]}, "R3 setpoints intact");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule